// File: doc/BRIEF.md
# Multi-core interrupt priority selector

This block decides, separately for every CPU of a cluster, which interrupt source that CPU should take next. Each source has an input line that is either edge- or level-sensitive, an enable bit, an 8-bit priority (a smaller value is more urgent) and a mask of the CPUs it may be delivered to. Sources with IDs below a configurable private boundary belong to every CPU and skip the mask. Every clock the block scans all sources for each CPU and registers the winner's ID, its priority and an interrupt request flag.

A CPU takes an interrupt by pulsing its acknowledge input. The block returns the live winner, clears that source's pending flag, marks it active, links the CPU's previously running interrupt to it and makes it the running interrupt. An end-of-interrupt word naming the running interrupt unwinds one nesting level: the running interrupt falls back to the one it interrupted. Nested handling therefore needs no stack outside the block.

Top module: `irq_prio_sel`

## Requirements
- R1: After synchronous reset every CPU reports winner ID 1023, priority 0xFF, request low, acknowledge result 1023 and running ID 1023.
- R2: A source competes only while it is both enabled and pending.
- R3: A source with ID below NUM_PRIV competes for every CPU; any other source competes for CPU c only when bit src_tgt[id*NUM_CPU + c] is set.
- R4: The winner is the competing source with the smallest priority value (src_prio[id*8 +: 8]); among equal priorities the lowest ID wins.
- R5: With no competing source the winner is 1023 and the priority reads 0xFF; irq_o[c] is high exactly when the registered winner is not 1023.
- R6: Winner outputs are registered from state one clock earlier: a source whose pending flag sets at edge k appears at edge k+1.
- R7: An acknowledge returns the CPU's current winner on ack_id at the next edge, clears its pending flag, marks it active and makes it the running ID; with no winner it returns 1023 and changes nothing.
- R8: When several CPUs acknowledge the same source in one cycle, only the lowest-numbered CPU receives it; the others receive 1023 and keep their running ID.
- R9: An end-of-interrupt uses only bits [9:0] of its 32-bit word; when they equal the running ID, the running ID returns to the interrupt that was running when that ID was acknowledged, and the source stops being active.
- R10: An end-of-interrupt naming any other ID, or arriving in the same cycle as a granted acknowledge on that CPU, leaves the running ID unchanged.
- R11: An edge source (src_edge=1) becomes pending on a rising edge of its line; a level source becomes pending while its line is high and it is not active, so a line still high after end-of-interrupt pends again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Interrupt lines, one per source |
| src_edge | input | NUM_SRC | 1 = edge-sensitive, 0 = level-sensitive |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*8 | Priority of source i in bits [i*8 +: 8] |
| src_tgt | input | NUM_SRC*NUM_CPU | CPU mask, bit i*NUM_CPU+c for CPU c |
| ack_req | input | NUM_CPU | Acknowledge pulse per CPU |
| eoi_valid | input | NUM_CPU | End-of-interrupt strobe per CPU |
| eoi_data | input | NUM_CPU*32 | End-of-interrupt word per CPU, ID in bits [9:0] |
| win_id | output | NUM_CPU*10 | Registered winner ID per CPU |
| win_prio | output | NUM_CPU*8 | Registered winner priority per CPU |
| irq_o | output | NUM_CPU | Interrupt request per CPU |
| ack_id | output | NUM_CPU*10 | Result of last cycle's acknowledge, 1023 otherwise |
| run_id | output | NUM_CPU*10 | Running interrupt per CPU |

## Verification
The bench goes after priority ties between sources targeted at both CPUs, where a scan that replaced on equal priority would report the higher ID, and a shared source targeted at only one CPU, which a missing mask check would leak to the other. It acknowledges the same source from both CPUs in one cycle, where a design without arbitration would hand one interrupt to two CPUs. It nests two interrupts on one CPU and unwinds them, so a lost predecessor link would drop the running ID straight to 1023, and it sends end-of-interrupt words with junk in the upper bits or a wrong ID, which a sloppy decoder would honour. A level line held high through its handler must stay silent while active and pend again afterwards.

// File: rtl/ips_pkg.sv
package ips_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int EOI_W  = 32;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;
endpackage

// File: rtl/ips_scan.sv
module ips_scan
  import ips_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      found,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  logic [PRIO_W:0] bp;

  // Linear scan, strict less-than keeps the lowest ID on a tie.
  always_comb begin
    bp      = {1'b1, {PRIO_W{1'b0}}};
    best_id = SPURIOUS_ID;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && ({1'b0, prio[i*PRIO_W +: PRIO_W]} < bp)) begin
        bp      = {1'b0, prio[i*PRIO_W +: PRIO_W]};
        best_id = ID_W'(i);
      end
    end
    found     = !bp[PRIO_W];
    best_prio = found ? bp[PRIO_W-1:0] : IDLE_PRIO;
  end
endmodule

// File: rtl/ips_src_state.sv
module ips_src_state #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] line,
  input  logic [NUM_SRC-1:0] edge_cfg,
  input  logic [NUM_SRC-1:0] clr_pend,
  input  logic [NUM_SRC-1:0] set_act,
  input  logic [NUM_SRC-1:0] clr_act,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] act
);
  logic [NUM_SRC-1:0] prev;
  logic [NUM_SRC-1:0] raise;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign raise[i] = edge_cfg[i] ? (line[i] & ~prev[i]) : (line[i] & ~act[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i] <= 1'b0;
        pend[i] <= 1'b0;
        act[i]  <= 1'b0;
      end else begin
        prev[i] <= line[i];
        pend[i] <= clr_pend[i] ? 1'b0 : (pend[i] | raise[i]);
        act[i]  <= set_act[i] | (act[i] & ~clr_act[i]);
      end
    end

    // R7: a granted source is no longer pending afterwards
    p_ack_clears_pend_r7: assert property (@(posedge clk) disable iff (rst)
      clr_pend[i] |=> !pend[i]);

    // R11: an active level source that is not pending stays quiet
    p_level_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      (act[i] && !edge_cfg[i] && !pend[i] && !set_act[i] && !clr_act[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/ips_cpu_ctx.sv
module ips_cpu_ctx
  import ips_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant,
  input  logic [ID_W-1:0] grant_id,
  input  logic            eoi_valid,
  input  logic [ID_W-1:0] eoi_id,
  output logic [ID_W-1:0] run_id,
  output logic            eoi_ok
);
  localparam int AW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [ID_W-1:0] link [NUM_SRC];
  logic [ID_W-1:0] link_rd;
  logic [ID_W-1:0] run_q;

  assign link_rd = link[eoi_id[AW-1:0]];
  assign eoi_ok  = eoi_valid && !grant && (run_q != SPURIOUS_ID) && (eoi_id == run_q);
  assign run_id  = run_q;

  // Predecessor links: plain write port, no reset, RAM-inferable.
  always_ff @(posedge clk) begin
    if (grant) link[grant_id[AW-1:0]] <= run_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         run_q <= SPURIOUS_ID;
    else if (grant)  run_q <= grant_id;
    else if (eoi_ok) run_q <= link_rd;
  end

  // R9: a matching end-of-interrupt restores the stored predecessor
  p_eoi_restores_r9: assert property (@(posedge clk) disable iff (rst)
    eoi_ok |=> (run_q == $past(link_rd)));

  // R10: a non-matching end-of-interrupt leaves the running ID alone
  p_eoi_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !grant && (eoi_id != run_q)) |=> $stable(run_q));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import ips_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          src_line,
  input  logic [NUM_SRC-1:0]          src_edge,
  input  logic [NUM_SRC-1:0]          src_en,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [NUM_SRC*NUM_CPU-1:0]  src_tgt,
  input  logic [NUM_CPU-1:0]          ack_req,
  input  logic [NUM_CPU-1:0]          eoi_valid,
  input  logic [NUM_CPU*EOI_W-1:0]    eoi_data,
  output logic [NUM_CPU*ID_W-1:0]     win_id,
  output logic [NUM_CPU*PRIO_W-1:0]   win_prio,
  output logic [NUM_CPU-1:0]          irq_o,
  output logic [NUM_CPU*ID_W-1:0]     ack_id,
  output logic [NUM_CPU*ID_W-1:0]     run_id
);
  logic [NUM_SRC-1:0] pend, act;
  logic [NUM_SRC-1:0] clr_pend, set_act, clr_act;
  logic [NUM_SRC-1:0] cand [NUM_CPU];
  logic               found [NUM_CPU];
  logic [ID_W-1:0]    best_id [NUM_CPU];
  logic [PRIO_W-1:0]  best_prio [NUM_CPU];
  logic [NUM_CPU-1:0] grant;
  logic [NUM_CPU-1:0] eoi_ok;
  logic [ID_W-1:0]    eoi_id [NUM_CPU];
  logic [NUM_CPU-1:0] gvec [NUM_SRC];
  logic               unused_eoi_hi;

  // Candidate masks: enabled, pending, and private or targeted.
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        cand[c][i] = src_en[i] & pend[i] & ((i < NUM_PRIV) || src_tgt[i*NUM_CPU + c]);
      end
    end
  end

  // Same-source acknowledge conflicts resolve to the lowest CPU.
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      grant[c] = ack_req[c] & found[c];
      for (int d = 0; d < NUM_CPU; d++) begin
        if ((d < c) && grant[d] && (best_id[d] == best_id[c])) grant[c] = 1'b0;
      end
    end
  end

  always_comb begin
    unused_eoi_hi = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) begin
      eoi_id[c]     = eoi_data[c*EOI_W +: ID_W];
      unused_eoi_hi = unused_eoi_hi ^ (^eoi_data[c*EOI_W+ID_W +: EOI_W-ID_W]);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      clr_act[i] = 1'b0;
      for (int c = 0; c < NUM_CPU; c++) begin
        gvec[i][c] = grant[c] && (best_id[c] == ID_W'(i));
        if (eoi_ok[c] && (eoi_id[c] == ID_W'(i))) clr_act[i] = 1'b1;
      end
      clr_pend[i] = |gvec[i];
      set_act[i]  = |gvec[i];
    end
  end

  ips_src_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst(rst), .line(src_line), .edge_cfg(src_edge),
    .clr_pend(clr_pend), .set_act(set_act), .clr_act(clr_act),
    .pend(pend), .act(act)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [ID_W-1:0]   win_q, ack_q, run_w;
    logic [PRIO_W-1:0] prio_q;
    logic              irq_q;

    ips_scan #(.NUM_SRC(NUM_SRC)) u_scan (
      .cand(cand[c]), .prio(src_prio),
      .found(found[c]), .best_id(best_id[c]), .best_prio(best_prio[c])
    );

    ips_cpu_ctx #(.NUM_SRC(NUM_SRC)) u_ctx (
      .clk(clk), .rst(rst), .grant(grant[c]), .grant_id(best_id[c]),
      .eoi_valid(eoi_valid[c]), .eoi_id(eoi_id[c]),
      .run_id(run_w), .eoi_ok(eoi_ok[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        win_q  <= SPURIOUS_ID;
        prio_q <= IDLE_PRIO;
        irq_q  <= 1'b0;
        ack_q  <= SPURIOUS_ID;
      end else begin
        win_q  <= best_id[c];
        prio_q <= best_prio[c];
        irq_q  <= found[c];
        ack_q  <= grant[c] ? best_id[c] : SPURIOUS_ID;
      end
    end

    assign win_id[c*ID_W +: ID_W]       = win_q;
    assign win_prio[c*PRIO_W +: PRIO_W] = prio_q;
    assign irq_o[c]                     = irq_q;
    assign ack_id[c*ID_W +: ID_W]       = ack_q;
    assign run_id[c*ID_W +: ID_W]       = run_w;

    // R5: request flag agrees with the registered winner
    p_irq_flag_r5: assert property (@(posedge clk) disable iff (rst)
      irq_q == (win_q != SPURIOUS_ID));

    // R7: acknowledge with nothing to take returns the spurious ID
    p_ack_empty_r7: assert property (@(posedge clk) disable iff (rst)
      (ack_req[c] && !found[c]) |=> (ack_q == SPURIOUS_ID));
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_once
    // R8: a source is handed to at most one CPU per cycle
    p_grant_once_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gvec[i]));
  end
endmodule

// File: tb/sim_irq_prio_sel.sv
`timescale 1ns/1ps
module sim_irq_prio_sel;
  localparam int NS = 64;
  localparam int NC = 2;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    line = '0, edg = '0, en = '0;
  logic [NS*8-1:0]  prio = '0;
  logic [NS*NC-1:0] tgt = '0;
  logic [NC-1:0]    ack = '0, eoiv = '0;
  logic [NC*32-1:0] eoid = '0;
  logic [NC*10-1:0] win_id, ack_id, run_id;
  logic [NC*8-1:0]  win_prio;
  logic [NC-1:0]    irq_o;

  always #2.5 clk = ~clk;

  irq_prio_sel #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_PRIV(NP)) u0 (
    .clk(clk), .rst(rst), .src_line(line), .src_edge(edg), .src_en(en),
    .src_prio(prio), .src_tgt(tgt), .ack_req(ack), .eoi_valid(eoiv),
    .eoi_data(eoid), .win_id(win_id), .win_prio(win_prio), .irq_o(irq_o),
    .ack_id(ack_id), .run_id(run_id)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, actual, expected, $time);
    end
  endtask

  function automatic int g_win(int c);  return int'(win_id[c*10 +: 10]);  endfunction
  function automatic int g_prio(int c); return int'(win_prio[c*8 +: 8]);  endfunction
  function automatic int g_ack(int c);  return int'(ack_id[c*10 +: 10]);  endfunction
  function automatic int g_run(int c);  return int'(run_id[c*10 +: 10]);  endfunction

  // ---------------- behavioural reference model ----------------
  bit m_ready = 0;
  bit m_pend[NS], m_act[NS], m_prev[NS];
  int m_last[NS][NC];
  int m_run[NC], m_win[NC], m_wprio[NC], m_irq[NC], m_ack[NC];
  int t_bi[NC], t_bp[NC], t_eid[NC];
  bit t_g[NC], t_eok[NC], t_na[NS], t_clr[NS];

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_act[i] = 0; m_prev[i] = 0; end
      for (int c = 0; c < NC; c++) begin
        m_run[c] = 1023; m_win[c] = 1023; m_wprio[c] = 255; m_irq[c] = 0; m_ack[c] = 1023;
      end
      m_ready = 1;
    end else begin
      for (int c = 0; c < NC; c++) begin
        t_bi[c] = 1023; t_bp[c] = 256;
        for (int i = 0; i < NS; i++) begin
          if (en[i] && m_pend[i] && (i < NP || tgt[i*NC+c]) && int'(prio[i*8 +: 8]) < t_bp[c]) begin
            t_bp[c] = int'(prio[i*8 +: 8]); t_bi[c] = i;
          end
        end
      end
      for (int c = 0; c < NC; c++) begin
        t_g[c] = ack[c] && t_bi[c] != 1023;
        for (int d = 0; d < c; d++) if (t_g[d] && t_bi[d] == t_bi[c]) t_g[c] = 0;
        t_eid[c] = int'(eoid[c*32 +: 10]);
        t_eok[c] = eoiv[c] && !t_g[c] && m_run[c] != 1023 && t_eid[c] == m_run[c];
      end
      foreach (t_na[i]) begin t_na[i] = m_act[i]; t_clr[i] = 0; end
      for (int c = 0; c < NC; c++) if (t_eok[c]) t_na[t_eid[c]] = 0;
      for (int c = 0; c < NC; c++) if (t_g[c]) begin t_na[t_bi[c]] = 1; t_clr[t_bi[c]] = 1; end
      for (int i = 0; i < NS; i++) begin
        bit rise;
        rise = edg[i] ? (line[i] && !m_prev[i]) : (line[i] && !m_act[i]);
        m_pend[i] = t_clr[i] ? 1'b0 : (m_pend[i] | rise);
        m_prev[i] = line[i];
        m_act[i]  = t_na[i];
      end
      for (int c = 0; c < NC; c++) begin
        if (t_g[c]) begin m_last[t_bi[c]][c] = m_run[c]; m_run[c] = t_bi[c]; end
        else if (t_eok[c]) m_run[c] = m_last[t_eid[c]][c];
        m_win[c]   = t_bi[c];
        m_wprio[c] = (t_bi[c] != 1023) ? t_bp[c] : 255;
        m_irq[c]   = (t_bi[c] != 1023) ? 1 : 0;
        m_ack[c]   = t_g[c] ? t_bi[c] : 1023;
      end
    end
  end

  // Compare with the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (m_ready && !rst && !done) begin
      for (int c = 0; c < NC; c++) begin
        chk("R4", g_win(c),  m_win[c],   "model winner id");
        chk("R4", g_prio(c), m_wprio[c], "model winner prio");
        chk("R5", int'(irq_o[c]), m_irq[c], "model irq");
        chk("R7", g_ack(c),  m_ack[c],   "model ack id");
        chk("R9", g_run(c),  m_run[c],   "model running id");
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(int i, int p, logic [NC-1:0] t, bit e);
    prio[i*8 +: 8] = 8'(p);
    tgt[i*NC +: NC] = t;
    edg[i] = e;
  endtask

  task automatic send_eoi(int c, int word);
    eoiv[c] = 1'b1; eoid[c*32 +: 32] = 32'(word);
    step(1);
    eoiv[c] = 1'b0; eoid[c*32 +: 32] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(3); rst = 1'b0; step(1);
  endtask

  initial begin
    en = '1;
    for (int i = 0; i < NS; i++) set_src(i, 200, '0, 1'b0);
    do_reset();
    for (int c = 0; c < NC; c++) begin
      chk("R1", g_win(c), 1023, "reset winner");
      chk("R1", g_prio(c), 255, "reset prio");
      chk("R1", int'(irq_o[c]), 0, "reset irq");
      chk("R1", g_ack(c), 1023, "reset ack");
      chk("R1", g_run(c), 1023, "reset running");
    end

    // Shared level source aimed at CPU1 only
    set_src(40, 5, 2'b10, 1'b0); line[40] = 1'b1;
    step(2);
    chk("R3", g_win(1), 40, "targeted cpu sees source");
    chk("R3", g_win(0), 1023, "untargeted cpu blind");
    chk("R5", int'(irq_o[0]), 0, "no request when empty");
    chk("R5", g_prio(0), 255, "empty prio");

    // Two edge sources with equal priority
    set_src(33, 3, 2'b11, 1'b1); set_src(35, 3, 2'b11, 1'b1);
    line[33] = 1'b1; line[35] = 1'b1;
    step(1);
    line[33] = 1'b0; line[35] = 1'b0;
    step(1);
    chk("R4", g_win(0), 33, "tie goes to lower id");
    chk("R4", g_prio(1), 3, "tie prio");
    chk("R11", g_win(1), 33, "edge source pended once");

    en[33] = 1'b0;
    step(2);
    chk("R2", g_win(0), 35, "disabled source skipped");

    // Both CPUs acknowledge 35 in the same cycle
    ack = 2'b11; step(1); ack = '0;
    chk("R8", g_ack(0), 35, "cpu0 wins conflict");
    chk("R8", g_ack(1), 1023, "cpu1 loses conflict");
    chk("R8", g_run(1), 1023, "loser keeps running id");
    chk("R7", g_run(0), 35, "ack sets running");
    step(1);
    chk("R7", g_win(0), 1023, "pending cleared by ack");

    send_eoi(0, 33);
    chk("R10", g_run(0), 35, "wrong id eoi ignored");
    send_eoi(0, 35 | (32'h0ABCDE << 10));
    chk("R9", g_run(0), 1023, "upper bits ignored, restore");

    // Level source held high through its handler
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    chk("R7", g_ack(1), 40, "cpu1 takes level source");
    step(3);
    chk("R11", g_win(1), 1023, "active level source quiet");
    send_eoi(1, 40);
    chk("R9", g_run(1), 1023, "eoi unwinds to idle");
    step(2);
    chk("R11", g_win(1), 40, "level source pends again");

    // Nesting on CPU1
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    chk("R7", g_run(1), 40, "outer running");
    en[33] = 1'b1;
    step(2);
    chk("R2", g_win(1), 33, "re-enabled source wins");
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    chk("R7", g_ack(1), 33, "inner acknowledge");
    send_eoi(1, 33);
    chk("R9", g_run(1), 40, "inner eoi restores outer");
    send_eoi(1, 40);
    chk("R9", g_run(1), 1023, "outer eoi restores idle");

    // Registered latency on a private source
    set_src(20, 1, 2'b00, 1'b0); line[20] = 1'b1;
    step(1);
    chk("R6", int'(g_win(0) != 20), 1, "not visible after one edge");
    step(1);
    chk("R6", g_win(0), 20, "visible after two edges");
    chk("R3", g_win(1), 20, "private source ignores mask");

    // Randomised phase against the model
    line = '0;
    do_reset();
    for (int blk = 0; blk < 5; blk++) begin
      for (int i = 0; i < NS; i++) begin
        set_src(i, int'($urandom % 6), NC'($urandom), 1'($urandom));
        en[i] = ($urandom % 8) != 0;
      end
      for (int k = 0; k < 500; k++) begin
        for (int i = 0; i < NS; i++) if ($urandom % 16 == 0) line[i] = ~line[i];
        for (int c = 0; c < NC; c++) begin
          int id;
          ack[c]  = ($urandom % 4) == 0;
          eoiv[c] = ($urandom % 3) == 0;
          id = ($urandom % 2) ? m_run[c] : int'($urandom % NS);
          eoid[c*32 +: 32] = 32'(id & 1023) | ($urandom << 10);
        end
        step(1);
      end
      ack = '0; eoiv = '0;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule